// File: doc/BRIEF.md
# Four-Bank SDRAM Command Sequencer

This block turns single read and write requests into the command stream that a four-bank SDRAM expects. Each request carries a bank, a row, a column, a read/write flag and an optional auto-precharge flag. The block presents one command per cycle on its command outputs, and the command is taken on the next rising clock edge. Each bank keeps a record of its open row. A request to the row that is already open is issued at once as a column command. A request to another row first closes the bank, waits the precharge time and opens the new row. A request to a closed bank opens it.

Each bank has its own timers for row-to-column delay, minimum row-active time and precharge time. This lets one bank be opening or closing itself, including through a self-timed auto precharge, while another bank is being accessed. An auto precharge starts at the end of the burst, but never before the minimum row-active time has passed since the bank was opened. The column command itself may already go out once the row-to-column delay has passed. A refresh timer raises a refresh request at a fixed interval. The block then holds off new requests, closes every open bank, issues AUTO REFRESH and keeps new activations back for the refresh cycle time.

Top module: `sdseq_top`

## Requirements
- R1: At most one command is presented per cycle on `cmd_o`, encoded as NOP=0, ACTIVE=1, READ=2, WRITE=3, PRECHARGE=4, AUTO REFRESH=5. `cmd_addr_o` carries the row for ACTIVE and the column for READ/WRITE.
- R2: A request whose bank is open on the requested row is issued as READ or WRITE with no ACTIVE or PRECHARGE before it.
- R3: A request to a closed bank produces ACTIVE with the request's row, then the column command with the request's column.
- R4: A request to an open bank on another row produces PRECHARGE of that bank. ACTIVE follows exactly T_RP cycles later and the column command T_RCD cycles after that.
- R5: A READ/WRITE is never issued earlier than T_RCD cycles after the ACTIVE of its bank. Two column commands are at least BL/2 cycles apart.
- R6: A request with auto precharge raises `cmd_ap_o` on its column command and no PRECHARGE is issued for it. The bank closes by itself at the later of BL/2 cycles after the column command and T_RAS cycles after its ACTIVE. The bank may be activated again T_RP cycles after that.
- R7: Every T_REFI cycles a refresh becomes pending. Open banks are precharged one per cycle, lowest bank first. AUTO REFRESH is issued once all banks are closed and their precharge time has elapsed.
- R8: No ACTIVE is issued within T_RFC cycles after AUTO REFRESH.
- R9: `req_ready_o` is low while a request is held, while a refresh is pending, and for T_RFC cycles from AUTO REFRESH.
- R10: Accessing one bank does not disturb the open row of another bank. A later row hit on that other bank is issued directly.
- R11: After reset, `cmd_o` is NOP, `req_ready_o` is high, all banks are closed, and no command is issued without a request or refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands take effect on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request is taken on a rising edge when valid and ready are both high |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_ap_i | input | 1 | Close the row by itself after the burst |
| req_bank_i | input | 2 | Target bank |
| req_row_i | input | ROW_W | Target row |
| req_col_i | input | COL_W | Starting column of the burst |
| cmd_o | output | 3 | Command code (see R1) |
| cmd_bank_o | output | 2 | Bank addressed by the command |
| cmd_addr_o | output | max(ROW_W,COL_W) | Row or column address |
| cmd_ap_o | output | 1 | Auto-precharge flag on READ/WRITE |

## Verification
The bench targets the timing corners where a wrong sequencer would still produce commands that look plausible. In the auto-precharge case where the minimum row-active time dominates, a design that closes the bank at the end of the burst would reactivate too early. In the case where the burst dominates, a design that waits for the row-active time alone would be off by cycles. For a row miss, a design that skipped the precharge or miscounted T_RP or T_RCD would show wrong gaps between PRECHARGE, ACTIVE and the column command. Around refresh the bench checks that every open bank is closed before AUTO REFRESH, that requests are refused through the refresh cycle time, and that rows left open in other banks still give direct hits. A design without per-bank tracking would issue needless activations there.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } sd_cmd_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // cycles a burst occupies the data pins (two beats per clock)
  function automatic int burst_cycles(input int bl);
    return (bl < 2) ? 1 : bl / 2;
  endfunction

  // width able to hold values 0..n
  function automatic int cnt_width(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/sdseq_bank.sv
module sdseq_bank
  import sdseq_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RAS = 8,
  parameter int BURST = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             rw_i,
  input  logic             ap_i,
  input  logic             pre_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             can_act_o,
  output logic             can_rw_o,
  output logic             can_pre_o,
  output logic             ap_fire_o
);
  localparam int LIM  = imax(T_RAS, T_RCD);
  localparam int AW   = cnt_width(LIM);
  localparam int PW   = cnt_width(T_RP);
  localparam int BW   = cnt_width(BURST);

  logic             open_q;
  logic [ROW_W-1:0] row_q;
  logic [AW-1:0]    ras_cnt_q;   // cycles since ACTIVE, saturating
  logic [PW-1:0]    pre_cnt_q;   // cycles left of precharge time
  logic [BW-1:0]    bst_cnt_q;   // cycles left of the current burst
  logic             ap_pend_q;

  logic rcd_met, ras_met;
  assign rcd_met = ras_cnt_q >= AW'(T_RCD);
  assign ras_met = ras_cnt_q >= AW'(T_RAS);

  assign ap_fire_o = open_q && ap_pend_q && (bst_cnt_q == '0) && ras_met;
  assign can_act_o = !open_q && (pre_cnt_q == '0);
  assign can_rw_o  = open_q && rcd_met && !ap_pend_q;
  assign can_pre_o = open_q && ras_met && !ap_pend_q;
  assign open_o    = open_q;
  assign row_o     = row_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      row_q     <= '0;
      ras_cnt_q <= '0;
      pre_cnt_q <= '0;
      bst_cnt_q <= '0;
      ap_pend_q <= 1'b0;
    end else begin
      if (act_i) begin
        open_q    <= 1'b1;
        row_q     <= row_i;
        ras_cnt_q <= AW'(1);
      end else if (ras_cnt_q < AW'(LIM)) begin
        ras_cnt_q <= ras_cnt_q + AW'(1);
      end

      if (pre_i || ap_fire_o) begin
        open_q    <= 1'b0;
        ap_pend_q <= 1'b0;
        pre_cnt_q <= PW'(T_RP - 1);
      end else if (pre_cnt_q != '0) begin
        pre_cnt_q <= pre_cnt_q - PW'(1);
      end

      if (rw_i) begin
        ap_pend_q <= ap_i;
        bst_cnt_q <= BW'(BURST - 1);
      end else if (bst_cnt_q != '0) begin
        bst_cnt_q <= bst_cnt_q - BW'(1);
      end
    end
  end

endmodule

// File: rtl/sdseq_refresh.sv
module sdseq_refresh
  import sdseq_pkg::*;
#(
  parameter int T_REFI = 780
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = cnt_width(T_REFI);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(T_REFI - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end

endmodule

// File: rtl/sdseq_sched.sv
module sdseq_sched
  import sdseq_pkg::*;
#(
  parameter int NB    = 4,
  parameter int ROW_W = 13,
  parameter int COL_W = 10,
  parameter int BURST = 2,
  parameter int T_RFC = 14,
  localparam int BANK_W = $clog2(NB),
  localparam int ADDR_W = imax(ROW_W, COL_W)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic                     req_write_i,
  input  logic                     req_ap_i,
  input  logic [BANK_W-1:0]        req_bank_i,
  input  logic [ROW_W-1:0]         req_row_i,
  input  logic [COL_W-1:0]         req_col_i,
  input  logic                     ref_tick_i,
  input  logic [NB-1:0]            open_v,
  input  logic [NB-1:0][ROW_W-1:0] row_v,
  input  logic [NB-1:0]            can_act_v,
  input  logic [NB-1:0]            can_rw_v,
  input  logic [NB-1:0]            can_pre_v,
  output logic [NB-1:0]            act_v,
  output logic [NB-1:0]            rw_v,
  output logic [NB-1:0]            pre_v,
  output logic [ROW_W-1:0]         act_row_o,
  output logic                     ap_o,
  output logic [2:0]               cmd_o,
  output logic [BANK_W-1:0]        cmd_bank_o,
  output logic [ADDR_W-1:0]        cmd_addr_o,
  output logic                     ref_pend_o
);
  localparam int RW_W = cnt_width(T_RFC);
  localparam int BS_W = cnt_width(BURST);

  logic              req_v_q, req_wr_q, req_ap_q;
  logic [BANK_W-1:0] req_bank_q;
  logic [ROW_W-1:0]  req_row_q;
  logic [COL_W-1:0]  req_col_q;
  logic              ref_pend_q;
  logic [RW_W-1:0]   rfc_cnt_q;
  logic [BS_W-1:0]   bus_cnt_q;

  sd_cmd_e           nxt_cmd;
  logic [BANK_W-1:0] tgt;
  logic [ADDR_W-1:0] addr;
  logic              ap;
  logic [BANK_W-1:0] pre_pick;
  logic              pre_found;
  logic              row_hit;
  logic              is_act, is_rw, is_pre, is_ref;

  assign row_hit = open_v[req_bank_q] && (row_v[req_bank_q] == req_row_q);

  always_comb begin
    nxt_cmd   = CMD_NOP;
    tgt       = '0;
    addr      = '0;
    ap        = 1'b0;
    pre_pick  = '0;
    pre_found = 1'b0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (open_v[i] && can_pre_v[i]) begin
        pre_pick  = BANK_W'(i);
        pre_found = 1'b1;
      end
    end
    if (ref_pend_q) begin
      if (pre_found) begin
        nxt_cmd = CMD_PRE;
        tgt     = pre_pick;
      end else if (&can_act_v) begin
        nxt_cmd = CMD_REF;
      end
    end else if (req_v_q) begin
      tgt = req_bank_q;
      if (row_hit) begin
        if (can_rw_v[req_bank_q] && (bus_cnt_q == '0)) begin
          nxt_cmd = req_wr_q ? CMD_WR : CMD_RD;
          addr    = ADDR_W'(req_col_q);
          ap      = req_ap_q;
        end
      end else if (open_v[req_bank_q]) begin
        if (can_pre_v[req_bank_q]) nxt_cmd = CMD_PRE;
      end else if (can_act_v[req_bank_q] && (rfc_cnt_q == '0)) begin
        nxt_cmd = CMD_ACT;
        addr    = ADDR_W'(req_row_q);
      end
    end
  end

  assign is_act = (nxt_cmd == CMD_ACT);
  assign is_rw  = (nxt_cmd == CMD_RD) || (nxt_cmd == CMD_WR);
  assign is_pre = (nxt_cmd == CMD_PRE);
  assign is_ref = (nxt_cmd == CMD_REF);

  assign act_v = NB'(is_act) << tgt;
  assign rw_v  = NB'(is_rw)  << tgt;
  assign pre_v = NB'(is_pre) << tgt;

  assign act_row_o   = req_row_q;
  assign ap_o        = ap;
  assign cmd_o       = nxt_cmd;
  assign cmd_bank_o  = tgt;
  assign cmd_addr_o  = addr;
  assign ref_pend_o  = ref_pend_q;
  assign req_ready_o = !req_v_q && !ref_pend_q && (rfc_cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_v_q    <= 1'b0;
      req_wr_q   <= 1'b0;
      req_ap_q   <= 1'b0;
      req_bank_q <= '0;
      req_row_q  <= '0;
      req_col_q  <= '0;
      ref_pend_q <= 1'b0;
      rfc_cnt_q  <= '0;
      bus_cnt_q  <= '0;
    end else begin
      if (req_valid_i && req_ready_o) begin
        req_v_q    <= 1'b1;
        req_wr_q   <= req_write_i;
        req_ap_q   <= req_ap_i;
        req_bank_q <= req_bank_i;
        req_row_q  <= req_row_i;
        req_col_q  <= req_col_i;
      end else if (is_rw) begin
        req_v_q <= 1'b0;
      end

      if (is_ref)     ref_pend_q <= 1'b0;
      if (ref_tick_i) ref_pend_q <= 1'b1;

      if (is_ref)                rfc_cnt_q <= RW_W'(T_RFC - 1);
      else if (rfc_cnt_q != '0)  rfc_cnt_q <= rfc_cnt_q - RW_W'(1);

      if (is_rw)                 bus_cnt_q <= BS_W'(BURST - 1);
      else if (bus_cnt_q != '0)  bus_cnt_q <= bus_cnt_q - BS_W'(1);
    end
  end

endmodule

// File: rtl/sdseq_top.sv
module sdseq_top
  import sdseq_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int BL     = 4,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 3,
  parameter int T_RAS  = 8,
  parameter int T_RFC  = 14,
  parameter int T_REFI = 780,
  localparam int NB     = 4,
  localparam int BANK_W = $clog2(NB),
  localparam int ADDR_W = imax(ROW_W, COL_W),
  localparam int BURST  = burst_cycles(BL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic              req_ap_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              cmd_ap_o
);
  // named internal events, observed by the bound checker
  logic [NB-1:0]            bank_open;
  logic [NB-1:0][ROW_W-1:0] bank_row;
  logic [NB-1:0]            bank_can_act, bank_can_rw, bank_can_pre;
  logic [NB-1:0]            ap_fire;
  logic [NB-1:0]            act_v, rw_v, pre_v;
  logic [ROW_W-1:0]         act_row;
  logic                     ap_flag;
  logic                     ref_tick;
  logic                     ref_pend;

  for (genvar g = 0; g < NB; g++) begin : g_bank
    sdseq_bank #(
      .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .BURST(BURST)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_i    (act_v[g]),
      .rw_i     (rw_v[g]),
      .ap_i     (ap_flag),
      .pre_i    (pre_v[g]),
      .row_i    (act_row),
      .open_o   (bank_open[g]),
      .row_o    (bank_row[g]),
      .can_act_o(bank_can_act[g]),
      .can_rw_o (bank_can_rw[g]),
      .can_pre_o(bank_can_pre[g]),
      .ap_fire_o(ap_fire[g])
    );
  end

  sdseq_refresh #(.T_REFI(T_REFI)) u_refresh (
    .clk   (clk),
    .rst_n (rst_n),
    .tick_o(ref_tick)
  );

  sdseq_sched #(
    .NB(NB), .ROW_W(ROW_W), .COL_W(COL_W), .BURST(BURST), .T_RFC(T_RFC)
  ) u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid_i(req_valid_i),
    .req_ready_o(req_ready_o),
    .req_write_i(req_write_i),
    .req_ap_i   (req_ap_i),
    .req_bank_i (req_bank_i),
    .req_row_i  (req_row_i),
    .req_col_i  (req_col_i),
    .ref_tick_i (ref_tick),
    .open_v     (bank_open),
    .row_v      (bank_row),
    .can_act_v  (bank_can_act),
    .can_rw_v   (bank_can_rw),
    .can_pre_v  (bank_can_pre),
    .act_v      (act_v),
    .rw_v       (rw_v),
    .pre_v      (pre_v),
    .act_row_o  (act_row),
    .ap_o       (ap_flag),
    .cmd_o      (cmd_o),
    .cmd_bank_o (cmd_bank_o),
    .cmd_addr_o (cmd_addr_o),
    .ref_pend_o (ref_pend)
  );

  assign cmd_ap_o = ap_flag;

endmodule

// File: rtl/sdseq_chk.sv
module sdseq_chk
  import sdseq_pkg::*;
#(
  parameter int NB    = 4,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RAS = 8,
  parameter int T_RFC = 14,
  localparam int BANK_W = $clog2(NB),
  localparam int LIM    = T_RCD + T_RP + T_RAS + T_RFC + 1,
  localparam int CW     = cnt_width(LIM)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cmd,
  input logic [BANK_W-1:0] cmd_bank,
  input logic              ready,
  input logic [NB-1:0]     bank_open,
  input logic [NB-1:0]     ap_fire,
  input logic              ref_pend
);
  logic is_act, is_rw, is_pre, is_ref;
  assign is_act = (cmd == CMD_ACT);
  assign is_rw  = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign is_pre = (cmd == CMD_PRE);
  assign is_ref = (cmd == CMD_REF);

  logic [CW-1:0] since_ref;
  logic          ref_seen;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_ref <= '0;
      ref_seen  <= 1'b0;
    end else if (is_ref) begin
      since_ref <= CW'(1);
      ref_seen  <= 1'b1;
    end else if (since_ref < CW'(LIM)) begin
      since_ref <= since_ref + CW'(1);
    end
  end

  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd <= 3'd5); // R1
  AST_REF_ALL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> (bank_open == '0)); // R7
  AST_RFC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act && ref_seen) |-> (since_ref >= CW'(T_RFC))); // R8
  AST_READY_IN_REF: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pend |-> !ready); // R9

  for (genvar g = 0; g < NB; g++) begin : g_bk
    logic          hit;
    logic [CW-1:0] since_act, since_close;
    logic          act_seen, close_seen;
    assign hit = (cmd_bank == BANK_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        since_act   <= '0;
        since_close <= '0;
        act_seen    <= 1'b0;
        close_seen  <= 1'b0;
      end else begin
        if (is_act && hit) begin
          since_act <= CW'(1);
          act_seen  <= 1'b1;
        end else if (since_act < CW'(LIM)) begin
          since_act <= since_act + CW'(1);
        end
        if ((is_pre && hit) || ap_fire[g]) begin
          since_close <= CW'(1);
          close_seen  <= 1'b1;
        end else if (since_close < CW'(LIM)) begin
          since_close <= since_close + CW'(1);
        end
      end
    end

    AST_RW_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rw && hit) |-> bank_open[g]); // R2
    AST_RCD_MET: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rw && hit) |-> (act_seen && since_act >= CW'(T_RCD))); // R5
    AST_RP_MET: assert property (@(posedge clk) disable iff (!rst_n)
      (is_act && hit && close_seen) |-> (since_close >= CW'(T_RP))); // R4
    AST_RAS_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
      ap_fire[g] |-> (act_seen && since_act >= CW'(T_RAS))); // R6
  end

endmodule

bind sdseq_top sdseq_chk #(
  .NB(NB), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RFC(T_RFC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd      (cmd_o),
  .cmd_bank (cmd_bank_o),
  .ready    (req_ready_o),
  .bank_open(bank_open),
  .ap_fire  (ap_fire),
  .ref_pend (ref_pend)
);

// File: tb/sdseq_top_bench.sv
module sdseq_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TB_ROW_W = 13;
  localparam int TB_COL_W = 10;
  localparam int TB_BL    = 8;
  localparam int TB_BURST = TB_BL / 2;
  localparam int TB_RCD   = 3;
  localparam int TB_RP    = 2;
  localparam int TB_RAS   = 9;
  localparam int TB_RFC   = 6;
  localparam int TB_REFI  = 400;

  localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3, C_PRE = 4, C_REF = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_ap = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [12:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic        req_ready;
  logic [2:0]  cmd;
  logic [1:0]  cmd_bank;
  logic [12:0] cmd_addr;
  logic        cmd_ap;

  sdseq_top #(
    .ROW_W(TB_ROW_W), .COL_W(TB_COL_W), .BL(TB_BL), .T_RCD(TB_RCD), .T_RP(TB_RP),
    .T_RAS(TB_RAS), .T_RFC(TB_RFC), .T_REFI(TB_REFI)
  ) u_sdseq_top (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_ap_i(req_ap), .req_bank_i(req_bank),
    .req_row_i(req_row), .req_col_i(req_col), .cmd_o(cmd), .cmd_bank_o(cmd_bank),
    .cmd_addr_o(cmd_addr), .cmd_ap_o(cmd_ap)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0;
  int n_log = 0;
  int l_cyc [0:511];
  int l_cmd [0:511];
  int l_bank[0:511];
  int l_addr[0:511];
  int l_ap  [0:511];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && cmd != 3'd0 && n_log < 512) begin
      l_cyc[n_log]  = cyc;
      l_cmd[n_log]  = int'(cmd);
      l_bank[n_log] = int'(cmd_bank);
      l_addr[n_log] = int'(cmd_addr);
      l_ap[n_log]   = int'(cmd_ap);
      n_log++;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) tick();
  endtask

  task automatic send(input bit wr, input int bank, input int row, input int col, input bit ap);
    @(negedge clk);
    req_write = wr; req_bank = 2'(bank); req_row = 13'(row);
    req_col = 10'(col); req_ap = ap; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic ent(input int idx, input int c, input int bank, input int addr, input string tag);
    bit ok;
    ok = (l_cmd[idx] == c) && (l_bank[idx] == bank) && (l_addr[idx] == addr);
    chk(ok, tag, $sformatf("entry %0d cmd*10000+bank*1000+addr", idx),
        l_cmd[idx] * 10000 + l_bank[idx] * 1000 + l_addr[idx], c * 10000 + bank * 1000 + addr);
  endtask

  task automatic wait_ref();
    int s;
    s = n_log;
    while (!(n_log > s && l_cmd[n_log-1] == C_REF)) tick();
  endtask

  task automatic t_reset();
    idle(2);
    chk(cmd == 3'd0, "R11", "cmd in reset", int'(cmd), C_NOP);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk(cmd == 3'd0, "R11", "cmd after reset", int'(cmd), C_NOP);
    chk(req_ready == 1'b1, "R11", "ready after reset", int'(req_ready), 1);
    idle(50);
    chk(n_log == 0, "R11", "commands issued while idle", n_log, 0);
  endtask

  task automatic t_closed_bank();
    int s;
    s = n_log;
    send(1'b0, 0, 5, 8, 1'b0);
    idle(15);
    chk(n_log - s == 2, "R3", "command count", n_log - s, 2);
    ent(s, C_ACT, 0, 5, "R1/R3 activate");
    ent(s + 1, C_RD, 0, 8, "R1/R3 read");
    chk(l_cyc[s+1] - l_cyc[s] == TB_RCD, "R5", "ACT to READ gap",
        l_cyc[s+1] - l_cyc[s], TB_RCD);
  endtask

  task automatic t_row_hit();
    int s;
    s = n_log;
    send(1'b1, 0, 5, 16, 1'b0);
    send(1'b0, 0, 5, 24, 1'b0);
    idle(15);
    chk(n_log - s == 2, "R2", "command count on hits", n_log - s, 2);
    ent(s, C_WR, 0, 16, "R2 write");
    ent(s + 1, C_RD, 0, 24, "R2 read");
    chk(l_cyc[s+1] - l_cyc[s] == TB_BURST, "R5", "column spacing",
        l_cyc[s+1] - l_cyc[s], TB_BURST);
  endtask

  task automatic t_row_miss();
    int s;
    s = n_log;
    send(1'b0, 0, 9, 3, 1'b0);
    idle(20);
    chk(n_log - s == 3, "R4", "command count on miss", n_log - s, 3);
    ent(s, C_PRE, 0, 0, "R4 precharge");
    ent(s + 1, C_ACT, 0, 9, "R4 activate");
    ent(s + 2, C_RD, 0, 3, "R4 read");
    chk(l_cyc[s+1] - l_cyc[s] == TB_RP, "R4", "PRE to ACT gap", l_cyc[s+1] - l_cyc[s], TB_RP);
    chk(l_cyc[s+2] - l_cyc[s+1] == TB_RCD, "R4", "ACT to READ gap",
        l_cyc[s+2] - l_cyc[s+1], TB_RCD);
  endtask

  // auto precharge where the row-active time dominates
  task automatic t_ap_lockout();
    int s;
    s = n_log;
    send(1'b0, 1, 3, 4, 1'b1);
    send(1'b0, 1, 3, 0, 1'b0);
    idle(25);
    chk(n_log - s == 4, "R6", "command count", n_log - s, 4);
    ent(s, C_ACT, 1, 3, "R6 first activate");
    ent(s + 1, C_RD, 1, 4, "R6 read");
    chk(l_ap[s+1] == 1, "R6", "auto precharge flag", l_ap[s+1], 1);
    ent(s + 2, C_ACT, 1, 3, "R6 reactivate without PRE");
    chk(l_cyc[s+2] - l_cyc[s] == TB_RAS + TB_RP, "R6", "ACT to re-ACT gap (lockout)",
        l_cyc[s+2] - l_cyc[s], TB_RAS + TB_RP);
  endtask

  // auto precharge where the burst end dominates
  task automatic t_ap_burst();
    int s;
    send(1'b0, 2, 4, 0, 1'b0);
    idle(20);
    s = n_log;
    send(1'b1, 2, 4, 8, 1'b1);
    send(1'b0, 2, 6, 2, 1'b0);
    idle(20);
    chk(n_log - s == 3, "R6", "command count", n_log - s, 3);
    ent(s, C_WR, 2, 8, "R6 write hit");
    ent(s + 1, C_ACT, 2, 6, "R6 activate after self close");
    chk(l_cyc[s+1] - l_cyc[s] == TB_BURST + TB_RP, "R6", "WRITE to ACT gap (burst end)",
        l_cyc[s+1] - l_cyc[s], TB_BURST + TB_RP);
  endtask

  task automatic t_banks_indep();
    int s;
    send(1'b0, 3, 7, 1, 1'b0);
    idle(10);
    s = n_log;
    send(1'b0, 1, 3, 8, 1'b0);
    send(1'b1, 3, 7, 12, 1'b0);
    idle(12);
    chk(n_log - s == 2, "R10", "commands for hits in two banks", n_log - s, 2);
    ent(s, C_RD, 1, 8, "R10 bank1 hit");
    ent(s + 1, C_WR, 3, 7'(12), "R10 bank3 hit");
  endtask

  task automatic t_refresh();
    int s, bad, r, f;
    s = n_log;
    bad = 0;
    while (n_log == s) tick();
    while (!(l_cmd[n_log-1] == C_REF)) begin
      if (req_ready) bad++;
      tick();
    end
    if (req_ready) bad++;
    r = n_log - 1;
    f = l_cyc[r];
    chk(r - s == 4, "R7", "precharges before refresh", r - s, 4);
    for (int i = 0; i < 4; i++) ent(s + i, C_PRE, i, 0, "R7 precharge order");
    chk(l_cyc[r] - l_cyc[r-1] == TB_RP, "R7", "last PRE to REF gap",
        l_cyc[r] - l_cyc[r-1], TB_RP);
    repeat (TB_RFC - 1) begin
      tick();
      if (req_ready) bad++;
    end
    chk(bad == 0, "R9", "ready high during refresh", bad, 0);
    tick();
    chk(req_ready == 1'b1, "R9", "ready after refresh time", int'(req_ready), 1);
    send(1'b0, 0, 9, 5, 1'b0);
    idle(10);
    ent(r + 1, C_ACT, 0, 9, "R7 bank closed by refresh");
    chk(l_cyc[r+1] - f >= TB_RFC, "R8", "REF to ACT gap", l_cyc[r+1] - f, TB_RFC);
  endtask

  initial begin
    t_reset();
    wait_ref();
    idle(TB_RFC + 2);
    t_closed_bank();
    t_row_hit();
    t_row_miss();
    t_ap_lockout();
    t_ap_burst();
    t_banks_indep();
    t_refresh();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule